// File: doc/BRIEF.md
# Multi-Tap Serial Audio Delay Line

This block takes a serial audio stream (a bit clock, one serial data bit per clock and a word-select level). It pushes the data bit and the word-select bit into two matching delay lines that advance on every rising bit-clock edge. A bank of output lanes then copies that stream. Each lane reads both its data and its word select from the same selectable position on the lines, so each lane is the input stream delayed by a whole number of bit-clock periods. When the lanes feed separate converters whose analog outputs are summed, the staggered copies interpolate between samples for a converter that runs without oversampling.

Each lane has its own tap index, which is written through a small write port (write enable, lane address and tap value) on the bit clock. A written value is held pending. It becomes the lane's active tap only on a word-select transition, so the delay of a lane never changes in the middle of a word. Lane outputs are registered on the falling bit-clock edge, so that converters downstream can capture them on the next rising edge. The reset input is asynchronous and active low, and its release is synchronised to the bit clock inside the block.

Top module: `tapped_stream_delay`

## Requirements
- R1: While reset is low, every lane output is 0. After reset, both delay lines hold 0 and every lane's active tap is 0, so each lane copies the current input bit.
- R2: A lane with active tap k drives, after the falling edge that follows the rising edge on which input bit n was presented, the data bit presented k rising edges earlier. Tap 0 is the current input bit, which has not yet been shifted.
- R3: On every lane the word-select output comes from the same tap index as the data output, so both carry the same delay.
- R4: Every lane can select any of the 64 tap positions independently of the others. Both evenly spaced sets (0, 8, …, 56) and irregular sets (0, 12, 24, 35, 45, 53, 59, 63) give the delays that were written.
- R5: A write (cfg_we high at a rising edge, cfg_lane = lane number, cfg_tap = tap index) changes only that lane's pending tap. The active tap takes the pending value at the first rising edge where the incoming word select differs from the word select of the previous bit. The new delay applies from the bit that follows that edge bit.
- R6: Tap 63, the deepest position, delays the stream by exactly 63 bit-clock periods.
- R7: When a lane is written twice before a word-select transition, the later value is the one that becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock. The delay lines shift on the rising edge and the outputs update on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sd_in | input | 1 | Serial data input |
| ws_in | input | 1 | Word-select input |
| cfg_we | input | 1 | Tap write enable |
| cfg_lane | input | 4 | Lane number for a tap write |
| cfg_tap | input | 6 | Tap index to write, 0 to 63 |
| lane_sd | output | 16 | Delayed data, one bit per lane |
| lane_ws | output | 16 | Delayed word select, one bit per lane |

## Verification
The bench drives a pseudo-random data stream so that each delay value gives its own bit sequence, and any error in the tap index shows up as a mismatch. It first runs with every tap at 0, then with an evenly spaced tap set and an irregular tap set loaded at the same time. This tells a wrong delay depth apart from a wrong lane-to-tap mapping. Writes made while word select is held constant show whether a new tap leaks through before a frame boundary. The word select toggles every 32 bits, so its delayed copies on each lane can be checked against the data delay. A double write to one lane in the middle of a frame shows which of the two values wins.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  localparam int TSD_LINE_DFLT  = 64;
  localparam int TSD_LANES_DFLT = 16;

  function automatic int tsd_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tsd_rst_sync.sv
module tsd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync = stage2_q;
endmodule

// File: rtl/tsd_tap_line.sv
module tsd_tap_line #(
  parameter int LEN = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_in,
  output logic [LEN-1:0] taps
);
  localparam int STAGES = LEN - 1;

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_nxt;

  always_comb begin
    sr_nxt = {sr_q[STAGES-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nxt;
  end

  // position 0 is the live input, position k is the input k clocks ago
  assign taps = {sr_q, bit_in};
endmodule

// File: rtl/tsd_tap_bank.sv
module tsd_tap_bank #(
  parameter int NL = 16,
  parameter int TW = 6,
  parameter int LW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ws_edge,
  input  logic           cfg_we,
  input  logic [LW-1:0]  cfg_lane,
  input  logic [TW-1:0]  cfg_tap,
  output logic [NL*TW-1:0] tap_pend,
  output logic [NL*TW-1:0] tap_act
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [TW-1:0] pend_q, pend_nxt;
    logic [TW-1:0] act_q, act_nxt;
    logic          wr_hit;

    assign wr_hit = cfg_we && (cfg_lane == LW'(i));

    always_comb begin
      pend_nxt = pend_q;
      act_nxt  = act_q;
      if (wr_hit)  pend_nxt = cfg_tap;
      if (ws_edge) act_nxt  = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        act_q  <= '0;
      end else begin
        pend_q <= pend_nxt;
        act_q  <= act_nxt;
      end
    end

    assign tap_pend[i*TW +: TW] = pend_q;
    assign tap_act[i*TW +: TW]  = act_q;
  end
endmodule

// File: rtl/tsd_lane_out.sv
module tsd_lane_out #(
  parameter int NL  = 16,
  parameter int LEN = 64,
  parameter int TW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN-1:0]   d_taps,
  input  logic [LEN-1:0]   w_taps,
  input  logic [NL*TW-1:0] tap_act,
  output logic [NL-1:0]    lane_sd,
  output logic [NL-1:0]    lane_ws
);
  for (genvar i = 0; i < NL; i++) begin : g_out
    logic [TW-1:0] sel;
    logic          d_nxt, w_nxt;
    logic          d_q, w_q;

    assign sel = tap_act[i*TW +: TW];

    always_comb begin
      d_nxt = d_taps[sel];
      w_nxt = w_taps[sel];
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= 1'b0;
        w_q <= 1'b0;
      end else begin
        d_q <= d_nxt;
        w_q <= w_nxt;
      end
    end

    assign lane_sd[i] = d_q;
    assign lane_ws[i] = w_q;
  end
endmodule

// File: rtl/tapped_stream_delay.sv
module tapped_stream_delay
  import tsd_pkg::*;
#(
  parameter int LEN = TSD_LINE_DFLT,
  parameter int NL  = TSD_LANES_DFLT,
  localparam int TW = tsd_idx_w(LEN),
  localparam int LW = tsd_idx_w(NL)
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          sd_in,
  input  logic          ws_in,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_lane,
  input  logic [TW-1:0] cfg_tap,
  output logic [NL-1:0] lane_sd,
  output logic [NL-1:0] lane_ws
);
  logic             rst_sync;
  logic [LEN-1:0]   d_taps;
  logic [LEN-1:0]   w_taps;
  logic [NL*TW-1:0] tap_pend;
  logic [NL*TW-1:0] tap_act;
  logic             ws_edge;

  tsd_rst_sync u_rst (
    .clk      (bclk),
    .rst_n    (rst_n),
    .rst_sync (rst_sync)
  );

  tsd_tap_line #(.LEN(LEN)) u_dline (
    .clk    (bclk),
    .rst_n  (rst_sync),
    .bit_in (sd_in),
    .taps   (d_taps)
  );

  tsd_tap_line #(.LEN(LEN)) u_wline (
    .clk    (bclk),
    .rst_n  (rst_sync),
    .bit_in (ws_in),
    .taps   (w_taps)
  );

  // word boundary: incoming select differs from the previous bit's select
  assign ws_edge = w_taps[0] ^ w_taps[1];

  tsd_tap_bank #(.NL(NL), .TW(TW), .LW(LW)) u_bank (
    .clk      (bclk),
    .rst_n    (rst_sync),
    .ws_edge  (ws_edge),
    .cfg_we   (cfg_we),
    .cfg_lane (cfg_lane),
    .cfg_tap  (cfg_tap),
    .tap_pend (tap_pend),
    .tap_act  (tap_act)
  );

  tsd_lane_out #(.NL(NL), .LEN(LEN), .TW(TW)) u_out (
    .clk     (bclk),
    .rst_n   (rst_sync),
    .d_taps  (d_taps),
    .w_taps  (w_taps),
    .tap_act (tap_act),
    .lane_sd (lane_sd),
    .lane_ws (lane_ws)
  );
endmodule

// File: rtl/tsd_checker.sv
module tsd_checker #(
  parameter int NL  = 16,
  parameter int LEN = 64,
  parameter int TW  = 6
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             sd_in,
  input logic             ws_in,
  input logic [LEN-1:0]   d_taps,
  input logic [LEN-1:0]   w_taps,
  input logic [NL*TW-1:0] tap_pend,
  input logic [NL*TW-1:0] tap_act
);
  AST_TAPS_CLEARED: assert property (@(posedge clk)
    $rose(rst_ok) |-> (tap_act == '0));  // R1

  AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> (d_taps[1] == $past(sd_in)) && (w_taps[1] == $past(ws_in)));  // R2

  AST_DEEPEST_STAGE: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> (d_taps[LEN-1] == $past(d_taps[LEN-2])));  // R6

  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (ws_in == w_taps[1]) |=> $stable(tap_act));  // R5

  AST_TAP_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    (ws_in != w_taps[1]) |=> (tap_act == $past(tap_pend)));  // R5
endmodule

bind tapped_stream_delay tsd_checker #(.NL(NL), .LEN(LEN), .TW(TW)) u_chk (
  .clk      (bclk),
  .rst_ok   (rst_sync),
  .sd_in    (sd_in),
  .ws_in    (ws_in),
  .d_taps   (d_taps),
  .w_taps   (w_taps),
  .tap_pend (tap_pend),
  .tap_act  (tap_act)
);

// File: tb/tb_tapped_stream_delay.sv
`timescale 1ns/1ps
module tb_tapped_stream_delay;
  localparam int NL = 16;
  localparam int HMAX = 1024;

  logic bclk = 1'b0;
  always #4 bclk = ~bclk;  // 125 MHz

  logic          rst_n;
  logic          sd_in, ws_in, cfg_we;
  logic [3:0]    cfg_lane;
  logic [5:0]    cfg_tap;
  logic [NL-1:0] lane_sd, lane_ws;

  tapped_stream_delay dut (
    .bclk(bclk), .rst_n(rst_n), .sd_in(sd_in), .ws_in(ws_in),
    .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_tap(cfg_tap),
    .lane_sd(lane_sd), .lane_ws(lane_ws)
  );

  typedef struct {
    int    lane;
    bit    ed;
    bit    ew;
    string tag;
  } item_t;

  item_t sb_q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    hd [HMAX];
  bit    hw [HMAX];
  int    pend [NL];
  int    act  [NL];
  bit    ws_prev = 1'b0;
  int    n = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit    done = 1'b0;

  task automatic note(input bit ok, input string tag, input int act_v, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // driver: presents one bit, pushes the expected lane values, advances the model
  task automatic step(input bit d, input bit w, input bit we = 1'b0,
                      input int ln = 0, input int tp = 0);
    @(posedge bclk); #1;
    sd_in = d; ws_in = w; cfg_we = we; cfg_lane = 4'(ln); cfg_tap = 6'(tp);
    hd[n] = d; hw[n] = w;
    for (int i = 0; i < NL; i++) begin
      item_t it;
      int k;
      k = act[i];
      it.lane = i;
      it.ed = (n - k >= 0) ? hd[n-k] : 1'b0;
      it.ew = (n - k >= 0) ? hw[n-k] : 1'b0;
      if (n < 4)                  it.tag = "R1";
      else if (pend[i] != act[i]) it.tag = "R5";
      else if (i == 3 && k == 40) it.tag = "R7";
      else if (k == 0)            it.tag = "R2";
      else if (k == 63)           it.tag = "R6";
      else                        it.tag = "R4";
      sb_q.push_back(it);
    end
    if (w != ws_prev) for (int i = 0; i < NL; i++) act[i] = pend[i];
    ws_prev = w;
    if (we) pend[ln] = tp;
    n++;
  endtask

  // monitor: compares after each falling edge
  initial begin
    forever begin
      @(negedge bclk); #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        note(lane_sd[it.lane] == it.ed, it.tag, int'(lane_sd[it.lane]), int'(it.ed));
        note(lane_ws[it.lane] == it.ew, "R3", int'(lane_ws[it.lane]), int'(it.ew));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int irr [8] = '{0, 12, 24, 35, 45, 53, 59, 63};
    for (int i = 0; i < NL; i++) begin pend[i] = 0; act[i] = 0; end
    rst_n = 1'b0; sd_in = 1'b1; ws_in = 1'b1; cfg_we = 1'b0; cfg_lane = '0; cfg_tap = '0;
    repeat (3) @(posedge bclk);
    @(negedge bclk); #1;
    // R1: outputs held low during reset even with inputs high
    note(lane_sd == '0, "R1", int'(lane_sd), 0);
    note(lane_ws == '0, "R1", int'(lane_ws), 0);
    sd_in = 1'b0; ws_in = 1'b0;
    @(posedge bclk); #1; rst_n = 1'b1;
    repeat (3) @(posedge bclk);

    // taps at reset value: lanes follow the input
    for (int s = 0; s < 8; s++) step(next_bit(), 1'b0);

    // load uniform set on lanes 0-7 and irregular set on lanes 8-15, select held low
    for (int i = 0; i < 8; i++)  step(next_bit(), 1'b0, 1'b1, i, i * 8);
    for (int i = 0; i < 8; i++)  step(next_bit(), 1'b0, 1'b1, 8 + i, irr[i]);
    for (int s = 0; s < 4; s++)  step(next_bit(), 1'b0);

    // framed stream: select toggles every 32 bits; double write to lane 3 mid-frame
    for (int f = 0; f < 200; f++) begin
      bit w;
      w = ((f / 32) % 2) == 0;
      if (f == 70)      step(next_bit(), w, 1'b1, 3, 5);
      else if (f == 71) step(next_bit(), w, 1'b1, 3, 40);
      else              step(next_bit(), w);
    end

    @(negedge bclk); #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule